// File: doc/BRIEF.md
# Network Controller Configuration Byte Pair with Power-Management Capability Control

This block holds two byte-wide configuration registers of a network controller and drives the power-management entry of its PCI configuration-space capability list. The first byte is a fixed identity byte that software can read but never change. The second byte mixes several kinds of bit:

- LED-mode bits, preset from the serial EEPROM while reset is held.
- A driver-loaded flag that hardware clears whenever the PCI command register is written.
- A wake-output mode bit.
- Two address-mapping status bits, taken from strap inputs.
- A vital-product-data enable. The data itself lives at EEPROM byte offsets 0x40 to 0x7F.
- A power-management enable, which only changes when the EEPROM control logic is in its programming mode.

The power-management enable decides whether the capability list shows a power-management entry. When it is set, the block reports the following to the configuration-space decoder, and clearing it removes every one of these:

- The new-capability status bit.
- A capability pointer of 0x50.
- A capability ID of 0x01.
- A null next pointer.
- A flag that marks the power-management registers at 0x52 to 0x57 as valid.

Software uses a simple local port with byte address, write data, write strobe and combinational read data. A write is captured on the rising clock edge. From the next cycle, read data and the capability outputs show the new state. Reset is synchronous and active low.

Top module: `nic_cfg_regs`

## Requirements
- R1: Offset 0x51 always reads 0x10: bits 4:3 read binary 10, and bits 7:5 and 2:0 read 0. Writes to it change nothing.
- R2: Bits 7:6 of offset 0x52 (LED mode, also on `led_mode_o`) load `eeprom_led` while `rst_n` is low. After reset they are read/write.
- R3: Bit 5 of offset 0x52 (driver loaded) resets to 0 and reads back the last value written. A `pci_cmd_wr` pulse clears it on the next edge, and this clear wins over a write in the same cycle.
- R4: Bit 4 of offset 0x52 (wake mode, also on `wake_mode_o`) is read/write and resets to 0.
- R5: Bit 3 of offset 0x52 reads `strap_mem_map` and bit 2 reads `strap_io_map`. Writes to these bits have no effect.
- R6: Bit 1 of offset 0x52 (VPD enable, also on `vpd_en_o`) is read/write and resets to 0.
- R7: Bit 0 of offset 0x52 (power-management enable, also on `pm_en_o`) resets to 0. A write takes effect only when `eem_mode` equals 2'b11; otherwise the bit keeps its value.
- R8: While the power-management enable is 1, the capability outputs read as follows: `cap_new` = 1, `cap_ptr` = 0x50, `cap_id` = 0x01, `cap_next` = 0x00 and `pm_regs_valid` = 1.
- R9: While the power-management enable is 0, `cap_new`, `cap_ptr`, `cap_id`, `cap_next` and `pm_regs_valid` are all 0.
- R10: Any offset other than 0x51 and 0x52 reads 0x00, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Local register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one byte per cycle |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| eeprom_led | input | 2 | LED-mode value loaded during reset |
| strap_mem_map | input | 1 | Strap: registers mapped in memory space |
| strap_io_map | input | 1 | Strap: registers mapped in I/O space |
| eem_mode | input | 2 | EEPROM control mode bits; 2'b11 unlocks the PM enable |
| pci_cmd_wr | input | 1 | Pulse marking a write to the PCI command register |
| led_mode_o | output | 2 | Current LED mode |
| wake_mode_o | output | 1 | Wake mode bit for the wake-output block |
| vpd_en_o | output | 1 | Vital product data enable |
| pm_en_o | output | 1 | Power-management enable |
| cap_new | output | 1 | Status register new-capability bit |
| cap_ptr | output | 8 | Capability pointer value |
| cap_id | output | 8 | Power-management capability ID |
| cap_next | output | 8 | Next-capability pointer |
| pm_regs_valid | output | 1 | Power-management registers at 0x52 to 0x57 are valid |

## Verification
A wrong stored bit in the second byte shows up on `reg_rdata` in the first cycle after the write or the command pulse that should have set it. Because the bench compares every read against its model every clock, a missed clear or a write that was not blocked is caught one cycle later. A power-management enable that is stuck, or that changes when it should not, also shows at once on all five capability outputs. The checks also cover fixed or strap-driven bits that accidentally became writable, and decodes that alias other offsets.

// File: rtl/nic_cfg_pkg.sv
package nic_cfg_pkg;
    localparam int BYTE_W = 8;

    // Bit positions inside the second configuration byte
    localparam int LED_HI  = 7;
    localparam int LED_LO  = 6;
    localparam int DRV_BIT = 5;
    localparam int WAK_BIT = 4;
    localparam int MEM_BIT = 3;
    localparam int IO_BIT  = 2;
    localparam int VPD_BIT = 1;
    localparam int PM_BIT  = 0;

    localparam logic [1:0] EEM_PROGRAM = 2'b11;

    typedef struct packed {
        logic [1:0] led;
        logic       drv;
        logic       wake;
        logic       vpd;
        logic       pm;
    } cfg1_t;
endpackage

// File: rtl/nic_cfg1_reg.sv
module nic_cfg1_reg
    import nic_cfg_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   led_init,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   eem_mode,
    input  logic         cmd_wr,
    output cfg1_t        state_q
);
    cfg1_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            state_d.led  = wdata[LED_HI:LED_LO];
            state_d.drv  = wdata[DRV_BIT];
            state_d.wake = wdata[WAK_BIT];
            state_d.vpd  = wdata[VPD_BIT];
            if (eem_mode == EEM_PROGRAM) begin
                state_d.pm = wdata[PM_BIT];
            end
        end
        if (cmd_wr) begin
            state_d.drv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{led: led_init, drv: 1'b0, wake: 1'b0, vpd: 1'b0, pm: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/nic_pm_cap.sv
module nic_pm_cap
    import nic_cfg_pkg::*;
#(
    parameter int              W        = BYTE_W,
    parameter logic [W-1:0]    CAP_BASE = 8'h50,
    parameter logic [W-1:0]    PM_ID    = 8'h01,
    parameter logic [W-1:0]    NEXT_PTR = 8'h00
) (
    input  logic         pm_en,
    output logic         cap_new,
    output logic [W-1:0] cap_ptr,
    output logic [W-1:0] cap_id,
    output logic [W-1:0] cap_next,
    output logic         pm_regs_valid
);
    always_comb begin
        cap_new       = pm_en;
        pm_regs_valid = pm_en;
        cap_ptr       = pm_en ? CAP_BASE : '0;
        cap_id        = pm_en ? PM_ID    : '0;
        cap_next      = pm_en ? NEXT_PTR : '0;
    end
endmodule

// File: rtl/nic_cfg_rdmux.sv
module nic_cfg_rdmux
    import nic_cfg_pkg::*;
#(
    parameter int           W         = BYTE_W,
    parameter logic [W-1:0] CFG0_ADDR = 8'h51,
    parameter logic [W-1:0] CFG1_ADDR = 8'h52,
    parameter logic [W-1:0] CFG0_VAL  = 8'h10
) (
    input  logic [W-1:0] addr,
    input  cfg1_t        cfg1,
    input  logic         strap_mem,
    input  logic         strap_io,
    output logic [W-1:0] rdata
);
    logic [W-1:0] cfg1_byte;

    always_comb begin
        cfg1_byte                 = '0;
        cfg1_byte[LED_HI:LED_LO]  = cfg1.led;
        cfg1_byte[DRV_BIT]        = cfg1.drv;
        cfg1_byte[WAK_BIT]        = cfg1.wake;
        cfg1_byte[MEM_BIT]        = strap_mem;
        cfg1_byte[IO_BIT]         = strap_io;
        cfg1_byte[VPD_BIT]        = cfg1.vpd;
        cfg1_byte[PM_BIT]         = cfg1.pm;
        if (addr == CFG0_ADDR) begin
            rdata = CFG0_VAL;
        end else if (addr == CFG1_ADDR) begin
            rdata = cfg1_byte;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_cfg_pkg::*;
#(
    parameter int           W         = BYTE_W,
    parameter logic [W-1:0] CFG0_ADDR = 8'h51,
    parameter logic [W-1:0] CFG1_ADDR = 8'h52
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reg_addr,
    input  logic [W-1:0] reg_wdata,
    input  logic         reg_we,
    output logic [W-1:0] reg_rdata,
    input  logic [1:0]   eeprom_led,
    input  logic         strap_mem_map,
    input  logic         strap_io_map,
    input  logic [1:0]   eem_mode,
    input  logic         pci_cmd_wr,
    output logic [1:0]   led_mode_o,
    output logic         wake_mode_o,
    output logic         vpd_en_o,
    output logic         pm_en_o,
    output logic         cap_new,
    output logic [W-1:0] cap_ptr,
    output logic [W-1:0] cap_id,
    output logic [W-1:0] cap_next,
    output logic         pm_regs_valid
);
    cfg1_t cfg1_q;
    logic  cfg1_hit;

    assign cfg1_hit = reg_we && (reg_addr == CFG1_ADDR);

    nic_cfg1_reg #(.W(W)) u_cfg1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .led_init (eeprom_led),
        .wr_hit   (cfg1_hit),
        .wdata    (reg_wdata),
        .eem_mode (eem_mode),
        .cmd_wr   (pci_cmd_wr),
        .state_q  (cfg1_q)
    );

    nic_cfg_rdmux #(.W(W), .CFG0_ADDR(CFG0_ADDR), .CFG1_ADDR(CFG1_ADDR)) u_rdmux (
        .addr      (reg_addr),
        .cfg1      (cfg1_q),
        .strap_mem (strap_mem_map),
        .strap_io  (strap_io_map),
        .rdata     (reg_rdata)
    );

    nic_pm_cap #(.W(W)) u_cap (
        .pm_en         (cfg1_q.pm),
        .cap_new       (cap_new),
        .cap_ptr       (cap_ptr),
        .cap_id        (cap_id),
        .cap_next      (cap_next),
        .pm_regs_valid (pm_regs_valid)
    );

    assign led_mode_o  = cfg1_q.led;
    assign wake_mode_o = cfg1_q.wake;
    assign vpd_en_o    = cfg1_q.vpd;
    assign pm_en_o     = cfg1_q.pm;
endmodule

// File: rtl/nic_cfg_regs_chk.sv
module nic_cfg_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic [1:0] eem_mode,
    input logic       pci_cmd_wr,
    input logic       wake_mode_o,
    input logic       pm_en_o,
    input logic       cap_new,
    input logic [7:0] cap_ptr,
    input logic [7:0] cap_id,
    input logic [7:0] cap_next,
    input logic       pm_regs_valid
);
    logic cfg1_wr;
    assign cfg1_wr = reg_we && (reg_addr == 8'h52);

    AST_CFG0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h51) |-> (reg_rdata == 8'h10)); // R1

    AST_DRV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_cmd_wr && reg_addr == 8'h52) |=> (reg_addr != 8'h52 || !reg_rdata[5])); // R3

    AST_WAKE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg1_wr |=> (wake_mode_o == $past(reg_wdata[4]))); // R4

    AST_PM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg1_wr && eem_mode == 2'b11) |=> $stable(pm_en_o)); // R7

    AST_CAP_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en_o |-> (cap_new && pm_regs_valid && cap_ptr == 8'h50 && cap_id == 8'h01 && cap_next == 8'h00)); // R8

    AST_CAP_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en_o |-> (!cap_new && !pm_regs_valid && cap_ptr == 8'h00 && cap_id == 8'h00 && cap_next == 8'h00)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 8'h51 && reg_addr != 8'h52) |-> (reg_rdata == 8'h00)); // R10
endmodule

bind nic_cfg_regs nic_cfg_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we),
    .reg_rdata     (reg_rdata),
    .eem_mode      (eem_mode),
    .pci_cmd_wr    (pci_cmd_wr),
    .wake_mode_o   (wake_mode_o),
    .pm_en_o       (pm_en_o),
    .cap_new       (cap_new),
    .cap_ptr       (cap_ptr),
    .cap_id        (cap_id),
    .cap_next      (cap_next),
    .pm_regs_valid (pm_regs_valid)
);

// File: tb/nic_cfg_regs_tb.sv
module nic_cfg_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic [1:0] eeprom_led = 2'b10;
    logic       strap_mem_map = 1'b1;
    logic       strap_io_map = 1'b0;
    logic [1:0] eem_mode = 2'b00;
    logic       pci_cmd_wr = 1'b0;
    logic [1:0] led_mode_o;
    logic       wake_mode_o, vpd_en_o, pm_en_o, cap_new, pm_regs_valid;
    logic [7:0] cap_ptr, cap_id, cap_next;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // behavioural model state
    int m_led, m_drv, m_wake, m_vpd, m_pm;

    always #5 clk = ~clk;

    nic_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .eeprom_led(eeprom_led),
        .strap_mem_map(strap_mem_map), .strap_io_map(strap_io_map),
        .eem_mode(eem_mode), .pci_cmd_wr(pci_cmd_wr), .led_mode_o(led_mode_o),
        .wake_mode_o(wake_mode_o), .vpd_en_o(vpd_en_o), .pm_en_o(pm_en_o),
        .cap_new(cap_new), .cap_ptr(cap_ptr), .cap_id(cap_id),
        .cap_next(cap_next), .pm_regs_valid(pm_regs_valid)
    );

    task automatic check(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int model_read(int a);
        if (a == 'h51) return 'h10;
        if (a == 'h52)
            return (m_led << 6) | (m_drv << 5) | (m_wake << 4) | (int'(strap_mem_map) << 3)
                 | (int'(strap_io_map) << 2) | (m_vpd << 1) | m_pm;
        return 0;
    endfunction

    task automatic compare_all(string tag);
        check(tag, reg_rdata, model_read(reg_addr));
        check("R2", led_mode_o, m_led);
        check("R4", wake_mode_o, m_wake);
        check("R6", vpd_en_o, m_vpd);
        check("R7", pm_en_o, m_pm);
        if (m_pm != 0) begin
            check("R8", {cap_new, pm_regs_valid, cap_ptr, cap_id, cap_next}, {2'b11, 24'h500100});
        end else begin
            check("R9", {cap_new, pm_regs_valid, cap_ptr, cap_id, cap_next}, 26'd0);
        end
    endtask

    // one cycle: drive at falling edge, compare, then advance the model at the rising edge
    task automatic step(string tag, int a, int wd, bit we, bit cmd, int eem);
        @(negedge clk);
        reg_addr = 8'(a); reg_wdata = 8'(wd); reg_we = we;
        pci_cmd_wr = cmd; eem_mode = 2'(eem);
        #1;
        compare_all(tag);
        @(posedge clk);
        if (we && a == 'h52) begin
            m_led  = (wd >> 6) & 3;
            m_drv  = (wd >> 5) & 1;
            m_wake = (wd >> 4) & 1;
            m_vpd  = (wd >> 1) & 1;
            if (eem == 3) m_pm = wd & 1;
        end
        if (cmd) m_drv = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        m_led = 2; m_drv = 0; m_wake = 0; m_vpd = 0; m_pm = 0;
        @(negedge clk);
        rst_n = 1'b1;
        eeprom_led = 2'b01; // must not matter after reset
        // reset state
        step("R2 reset", 'h52, 0, 0, 0, 0);
        check("R3 reset", reg_rdata[5], 0);
        step("R1 read", 'h51, 0, 0, 0, 0);
        step("R1 write", 'h51, 'hFF, 1, 0, 3);
        step("R1 after write", 'h51, 0, 0, 0, 0);
        step("R10 unmapped", 'h50, 'hFF, 1, 0, 3);
        step("R10 unmapped", 'h53, 'hFF, 1, 0, 3);
        step("R10 state kept", 'h52, 0, 0, 0, 0);
        // write all ones with PM locked
        step("R7 locked write", 'h52, 'hFF, 1, 0, 0);
        step("R5 straps", 'h52, 0, 0, 0, 0);
        step("R7 locked eem=01", 'h52, 'h01, 1, 0, 1);
        step("R7 locked eem=10", 'h52, 'h01, 1, 0, 2);
        step("R7 readback", 'h52, 0, 0, 0, 0);
        // unlock and enable PM
        step("R7 unlocked", 'h52, 'h61, 1, 0, 3);
        step("R8 cap on", 'h52, 0, 0, 0, 0);
        // driver flag cleared by command write
        step("R3 cmd clear", 'h52, 0, 0, 1, 0);
        step("R3 after clear", 'h52, 'h21, 1, 0, 0);
        step("R3 set again", 'h52, 'h20, 1, 1, 0);
        step("R3 clear wins", 'h52, 0, 0, 0, 0);
        // strap changes
        strap_mem_map = 1'b0; strap_io_map = 1'b1;
        step("R5 strap change", 'h52, 'h0C, 1, 0, 0);
        step("R5 write ignored", 'h52, 0, 0, 0, 0);
        step("R4 wake set", 'h52, 'h90, 1, 0, 0);
        step("R6 vpd set", 'h52, 'h02, 1, 0, 0);
        step("R6 readback", 'h52, 0, 0, 0, 0);
        // PM off again
        step("R9 pm off", 'h52, 'h00, 1, 0, 3);
        step("R9 cap off", 'h52, 0, 0, 0, 0);
        step("R10 high addr", 'hFF, 'h5A, 1, 1, 3);
        step("R2 final", 'h52, 0, 0, 0, 0);
        step("R1 final", 'h51, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule